// File: doc/BRIEF.md
# ECC Syndrome DIMM Locator

This block turns a corrected-memory error report into the memory module and connector pin that most likely failed. Each report carries a syndrome code from the ECC checker, the physical address of the access and the bank number plus hit flag from the address decoder. A single-bit error names exactly one module of the bank's group and the pin on that module's connector. A multi-bit error cannot be narrowed down, so the whole group of four modules is flagged. A report with a code outside the legal range, or one that no bank claimed, comes back as unknown.

The translation is table-driven. Two layout map sets are held inside the block, each made of a packed module map (four 2-bit entries per byte) and a pin map with one byte per bit of a 64-byte line. A flag chooses between the symmetric set (set 0) and the asymmetric set (set 1). Both sets and the flag are loaded through a simple write port, normally once at boot. Lookups are pipelined over three stages and can be issued every cycle.

Top module: `ecc_dimm_locator`

## Requirements
- R1: While reset is held and after it is released, until a lookup result is due, out_valid is 0 and out_unknown, out_multi, out_mask, out_dimm and out_pin are all 0; these outputs are also all 0 in every cycle in which out_valid is 0.
- R2: A request accepted at a rising edge produces out_valid high for exactly one cycle, starting after the third rising edge counted from the accepting one (the accepting edge counts as the first); requests on consecutive cycles produce results on consecutive cycles.
- R3: When req_bank_hit is 0, or the syndrome (9-bit two's complement) is below -1 or above 144, the result has out_unknown=1 with out_multi, out_mask, out_dimm and out_pin all 0.
- R4: A syndrome of -1 with a bank hit is a multi-bit error: out_multi=1, out_mask=4'b1111, out_dimm equals (req_bank bit 0) times 4, and out_pin is 0.
- R5: For a single-bit error the syndrome is turned into a bus bit: codes 0..127 add 16, codes 128..143 subtract 137, code 144 subtracts 143.
- R6: The line position is (3 - req_addr[5:4]) times 144 plus the bus bit; a negative position gives out_unknown=1.
- R7: With map index m = 575 - position, the module map byte at m/4 is read and bit (3 - (m mod 4)) times 2 of it is the entry e (0 or 1); out_dimm = (req_bank bit 0) times 4 + e and out_mask has only bit e set.
- R8: For a single-bit error, out_pin is the pin map entry at the line position.
- R9: When the symmetric flag is 1 map set 0 is used, otherwise map set 1; the flag is 0 after reset and is loaded by sym_wr with sym_val.
- R10: A write with wr_en=1 stores wr_data into the module map (wr_pin_map=0, addresses 0..143) or the pin map (wr_pin_map=1, addresses 0..575) of set wr_set; writes to addresses beyond those ranges change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Error report present this cycle |
| req_syndrome | input | SYND_W | Syndrome code, two's complement, -1 means multi-bit |
| req_addr | input | ADDR_W | Physical address of the failing access |
| req_bank | input | BANK_W | Bank number from the address decoder |
| req_bank_hit | input | 1 | The decoder found a bank for the address |
| wr_en | input | 1 | Map write strobe |
| wr_pin_map | input | 1 | 1 selects the pin map, 0 the module map |
| wr_set | input | 1 | Map set written |
| wr_addr | input | 10 | Byte address within the selected map |
| wr_data | input | 8 | Byte written |
| sym_wr | input | 1 | Load the symmetric flag |
| sym_val | input | 1 | Value for the symmetric flag |
| out_valid | output | 1 | Result present this cycle |
| out_unknown | output | 1 | Report could not be located |
| out_multi | output | 1 | Multi-bit error, whole group flagged |
| out_dimm | output | 3 | Module index (first of the group for multi-bit) |
| out_mask | output | 4 | Modules flagged within the group |
| out_pin | output | 8 | Connector pin for a single-bit error |

## Verification
Every result is due after the third rising edge counted from the edge that accepts the request, so the bench drives requests on falling edges and reads the outputs on the third falling edge after driving, then checks on the following falling edge that out_valid has dropped. A burst of three requests on consecutive cycles is read back on three consecutive falling edges. Expected results come from the bench's own copy of the maps it loaded, passed through the remap and index arithmetic of the requirements, over every code from -3 to 150, every quadword, both groups and both map sets.

// File: rtl/ecc_loc_pkg.sv
// Shared constants, types and the syndrome remap for the ECC DIMM locator.
// Assumes the fixed line layout: four quadwords of 144 bits per 64-byte line.
package ecc_loc_pkg;

    localparam int QW_BITS         = 144;
    localparam int QW_PER_LINE     = 4;
    localparam int LINE_BITS       = QW_BITS * QW_PER_LINE;
    localparam int ENTRIES_PER_B   = 4;
    localparam int DMAP_BYTES      = LINE_BITS / ENTRIES_PER_B;
    localparam int POS_W           = $clog2(LINE_BITS);
    localparam int DIDX_W          = $clog2(DMAP_BYTES);
    localparam int CODE_W          = 11;
    localparam int PIN_W           = 8;
    localparam int MAP_SETS        = 2;
    localparam int GROUPS          = 2;
    localparam int DIMMS_PER_GROUP = 4;
    localparam int DIMM_W          = $clog2(GROUPS * DIMMS_PER_GROUP);
    localparam int QW_LSB          = $clog2(64 / QW_PER_LINE);

    localparam logic signed [CODE_W-1:0] CODE_MULTI = -11'sd1;
    localparam logic signed [CODE_W-1:0] CODE_MAX   = CODE_W'(QW_BITS);

    typedef struct packed {
        logic                     valid;
        logic                     unknown;
        logic                     multi;
        logic signed [CODE_W-1:0] bus_bit;
        logic [1:0]               qw;
        logic                     group;
    } s1_t;

    typedef struct packed {
        logic             valid;
        logic             unknown;
        logic             multi;
        logic [POS_W-1:0] line_pos;
        logic [POS_W-1:0] where;
        logic             group;
    } s2_t;

    // Convert a syndrome code into its bit position on the bus.
    function automatic logic signed [CODE_W-1:0] remap_code(input logic signed [CODE_W-1:0] c);
        int v;
        v = int'(c);
        if (v < QW_BITS - 16)      return CODE_W'(v + 16);
        else if (v < QW_BITS)      return CODE_W'(v - (QW_BITS - 7));
        else if (v < QW_BITS + 3)  return CODE_W'(v - (QW_BITS - 1));
        else                       return CODE_W'(v - (QW_BITS + 3));
    endfunction

endpackage

// File: rtl/ecc_loc_remap.sv
// Stage 1: classifies the report (unknown / multi-bit / single-bit),
// remaps the syndrome to bus bit order and captures quadword and group.
// Assumes SYND_W < CODE_W and ADDR_W > 6.
module ecc_loc_remap
    import ecc_loc_pkg::*;
#(
    parameter int SYND_W = 9,
    parameter int ADDR_W = 16,
    parameter int BANK_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic signed [SYND_W-1:0] req_syndrome,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [BANK_W-1:0]        req_bank,
    input  logic                     req_bank_hit,
    output s1_t                      s1
);

    logic signed [CODE_W-1:0] code_ext;
    logic                     in_range;
    logic                     unused_req_bits;

    assign unused_req_bits = ^{req_addr[ADDR_W-1:QW_LSB+2], req_addr[QW_LSB-1:0],
                               req_bank[BANK_W-1:1]};

    // Sign-extend the code and test it against the legal range.
    always_comb begin
        code_ext = {{(CODE_W-SYND_W){req_syndrome[SYND_W-1]}}, req_syndrome};
        in_range = (code_ext >= CODE_MULTI) && (code_ext <= CODE_MAX);
    end

    // Register the classification and the remapped bus bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0;
        end else begin
            s1.valid   <= req_valid;
            s1.unknown <= !(req_bank_hit && in_range);
            s1.multi   <= req_bank_hit && (code_ext == CODE_MULTI);
            s1.bus_bit <= remap_code(code_ext);
            s1.qw      <= req_addr[QW_LSB+1:QW_LSB];
            s1.group   <= req_bank[0];
        end
    end

endmodule

// File: rtl/ecc_loc_index.sv
// Stage 2: combines quadword and bus bit into the position within the line
// and the mirrored map position; a position outside the line is unknown.
module ecc_loc_index
    import ecc_loc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  s1_t  s1,
    output s2_t  s2
);

    int   pos_i;
    logic pos_ok;

    // Position of the failing bit within the 576-bit line.
    always_comb begin
        pos_i  = (QW_PER_LINE - 1 - int'(s1.qw)) * QW_BITS + int'(s1.bus_bit);
        pos_ok = (pos_i >= 0) && (pos_i < LINE_BITS);
    end

    // Register positions, clearing them when they are not usable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2 <= '0;
        end else begin
            s2.valid    <= s1.valid;
            s2.multi    <= s1.multi && !s1.unknown;
            s2.group    <= s1.group;
            s2.unknown  <= s1.unknown || (!s1.multi && !pos_ok);
            s2.line_pos <= pos_ok ? POS_W'(pos_i) : '0;
            s2.where    <= pos_ok ? POS_W'(LINE_BITS - 1 - pos_i) : '0;
        end
    end

endmodule

// File: rtl/ecc_loc_maps.sv
// Stage 3: holds both layout map sets and the symmetric flag, serves the
// write port, reads the maps for the stage-2 positions and drives the
// registered result. Map contents are not reset; they are loaded at boot.
module ecc_loc_maps
    import ecc_loc_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  s2_t                        s2,
    input  logic                       wr_en,
    input  logic                       wr_pin_map,
    input  logic                       wr_set,
    input  logic [POS_W-1:0]           wr_addr,
    input  logic [7:0]                 wr_data,
    input  logic                       sym_wr,
    input  logic                       sym_val,
    output logic                       out_valid,
    output logic                       out_unknown,
    output logic                       out_multi,
    output logic [DIMM_W-1:0]          out_dimm,
    output logic [DIMMS_PER_GROUP-1:0] out_mask,
    output logic [PIN_W-1:0]           out_pin
);

    logic             sym_q;
    logic [7:0]       byte_rd [MAP_SETS];
    logic [PIN_W-1:0] pin_rd  [MAP_SETS];
    logic             set_sel;
    logic [7:0]       sel_byte;
    logic             entry;

    // Symmetric flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)      sym_q <= 1'b0;
        else if (sym_wr) sym_q <= sym_val;
    end

    for (genvar s = 0; s < MAP_SETS; s++) begin : g_set
        logic [7:0]       dmap [DMAP_BYTES];
        logic [PIN_W-1:0] pmap [LINE_BITS];

        // Write port for this set, ignoring addresses past each map's end.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_set == 1'(s)) && !wr_pin_map && (wr_addr < POS_W'(DMAP_BYTES)))
                dmap[wr_addr[DIDX_W-1:0]] <= wr_data;
            if (wr_en && (wr_set == 1'(s)) && wr_pin_map && (wr_addr < POS_W'(LINE_BITS)))
                pmap[wr_addr] <= wr_data[PIN_W-1:0];
        end

        assign byte_rd[s] = dmap[s2.where[POS_W-1:2]];
        assign pin_rd[s]  = pmap[s2.line_pos];
    end

    // Pick the set and extract the packed module entry.
    always_comb begin
        set_sel  = !sym_q;
        sel_byte = byte_rd[set_sel];
        entry    = sel_byte[{~s2.where[1:0], 1'b0}];
    end

    // Registered result; everything but out_valid is zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_unknown <= 1'b0;
            out_multi   <= 1'b0;
            out_dimm    <= '0;
            out_mask    <= '0;
            out_pin     <= '0;
        end else begin
            out_valid   <= s2.valid;
            out_unknown <= 1'b0;
            out_multi   <= 1'b0;
            out_dimm    <= '0;
            out_mask    <= '0;
            out_pin     <= '0;
            if (s2.valid) begin
                if (s2.unknown) begin
                    out_unknown <= 1'b1;
                end else if (s2.multi) begin
                    out_multi <= 1'b1;
                    out_mask  <= '1;
                    out_dimm  <= {s2.group, 2'b00};
                end else begin
                    out_dimm  <= {s2.group, 1'b0, entry};
                    out_mask  <= entry ? 4'b0010 : 4'b0001;
                    out_pin   <= pin_rd[set_sel];
                end
            end
        end
    end

endmodule

// File: rtl/ecc_dimm_locator.sv
// Top of the ECC DIMM locator: three-stage lookup from an error report to
// the failing module and pin. Assumes the decoder supplies bank and hit.
module ecc_dimm_locator
    import ecc_loc_pkg::*;
#(
    parameter int SYND_W = 9,
    parameter int ADDR_W = 16,
    parameter int BANK_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic signed [SYND_W-1:0]   req_syndrome,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [BANK_W-1:0]          req_bank,
    input  logic                       req_bank_hit,
    input  logic                       wr_en,
    input  logic                       wr_pin_map,
    input  logic                       wr_set,
    input  logic [POS_W-1:0]           wr_addr,
    input  logic [7:0]                 wr_data,
    input  logic                       sym_wr,
    input  logic                       sym_val,
    output logic                       out_valid,
    output logic                       out_unknown,
    output logic                       out_multi,
    output logic [DIMM_W-1:0]          out_dimm,
    output logic [DIMMS_PER_GROUP-1:0] out_mask,
    output logic [PIN_W-1:0]           out_pin
);

    s1_t s1;
    s2_t s2;

    ecc_loc_remap #(.SYND_W(SYND_W), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_remap (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_syndrome(req_syndrome),
        .req_addr(req_addr), .req_bank(req_bank), .req_bank_hit(req_bank_hit), .s1(s1)
    );

    ecc_loc_index u_index (.clk(clk), .rst_n(rst_n), .s1(s1), .s2(s2));

    ecc_loc_maps u_maps (
        .clk(clk), .rst_n(rst_n), .s2(s2),
        .wr_en(wr_en), .wr_pin_map(wr_pin_map), .wr_set(wr_set),
        .wr_addr(wr_addr), .wr_data(wr_data), .sym_wr(sym_wr), .sym_val(sym_val),
        .out_valid(out_valid), .out_unknown(out_unknown), .out_multi(out_multi),
        .out_dimm(out_dimm), .out_mask(out_mask), .out_pin(out_pin)
    );

endmodule

// File: rtl/ecc_dimm_locator_chk.sv
// Port-level checker for the ECC DIMM locator, bound to the top module.
module ecc_dimm_locator_chk
    import ecc_loc_pkg::*;
(
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_bank_hit,
    input logic                       out_valid,
    input logic                       out_unknown,
    input logic                       out_multi,
    input logic [DIMM_W-1:0]          out_dimm,
    input logic [DIMMS_PER_GROUP-1:0] out_mask,
    input logic [PIN_W-1:0]           out_pin
);

    logic [1:0] since_rst;

    // Counts edges since reset, saturating once the pipeline has filled.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= 2'd0;
        else if (since_rst != 3)  since_rst <= since_rst + 2'd1;
    end

    AST_RESULT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(req_valid, 3))); // R2

    AST_MISS_UNKNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        ((since_rst == 2'd3) && $past(req_valid && !req_bank_hit, 3)) |-> out_unknown); // R3

    AST_UNKNOWN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_unknown) |-> (!out_multi && out_mask == '0 && out_pin == '0 && out_dimm == '0)); // R3

    AST_MULTI_WHOLE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_multi) |-> (out_mask == '1 && out_dimm[1:0] == 2'b00 && out_pin == '0)); // R4

    AST_SINGLE_ONE_DIMM: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_unknown && !out_multi) |-> ($countones(out_mask) == 1 && out_mask[3:2] == 2'b00)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_unknown && !out_multi && out_mask == '0 && out_pin == '0 && out_dimm == '0)); // R1

endmodule

bind ecc_dimm_locator ecc_dimm_locator_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bank_hit(req_bank_hit),
    .out_valid(out_valid), .out_unknown(out_unknown), .out_multi(out_multi),
    .out_dimm(out_dimm), .out_mask(out_mask), .out_pin(out_pin)
);

// File: tb/tb_ecc_dimm_locator.sv
// Sweep bench for the ECC DIMM locator with an arithmetic reference model.
module tb_ecc_dimm_locator;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic signed [8:0] req_syndrome = '0;
    logic [15:0]       req_addr = '0;
    logic [3:0]        req_bank = '0;
    logic              req_bank_hit = 1'b0;
    logic              wr_en = 1'b0;
    logic              wr_pin_map = 1'b0;
    logic              wr_set = 1'b0;
    logic [9:0]        wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              sym_wr = 1'b0;
    logic              sym_val = 1'b0;
    logic              out_valid, out_unknown, out_multi;
    logic [2:0]        out_dimm;
    logic [3:0]        out_mask;
    logic [7:0]        out_pin;

    int   n_checks = 0;
    int   n_fail = 0;
    bit   done = 0;
    bit   sym_now = 0;
    logic [7:0] m_dmap [2][144];
    logic [7:0] m_pmap [2][576];

    always #10 clk = ~clk;

    ecc_dimm_locator dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_syndrome(req_syndrome),
        .req_addr(req_addr), .req_bank(req_bank), .req_bank_hit(req_bank_hit),
        .wr_en(wr_en), .wr_pin_map(wr_pin_map), .wr_set(wr_set), .wr_addr(wr_addr),
        .wr_data(wr_data), .sym_wr(sym_wr), .sym_val(sym_val),
        .out_valid(out_valid), .out_unknown(out_unknown), .out_multi(out_multi),
        .out_dimm(out_dimm), .out_mask(out_mask), .out_pin(out_pin)
    );

    task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual {v,unk,multi,dimm,mask,pin}=%h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [17:0] outs();
        return {out_valid, out_unknown, out_multi, out_dimm, out_mask, out_pin};
    endfunction

    // Expected result for one report, straight from the requirements.
    function automatic logic [17:0] model(input int code, input int qw, input int bank,
                                          input bit hit, output string tag);
        int bus, pos, where, set, e;
        logic [7:0] b;
        if (!hit || code < -1 || code > 144) begin
            tag = "R3 unknown";
            return {1'b1, 1'b1, 1'b0, 3'd0, 4'd0, 8'd0};
        end
        if (code == -1) begin
            tag = "R4 multi";
            return {1'b1, 1'b0, 1'b1, 3'(((bank & 1) * 4)), 4'hF, 8'd0};
        end
        if (code < 128)      bus = code + 16;
        else if (code < 144) bus = code - 137;
        else                 bus = code - 143;
        pos = (3 - qw) * 144 + bus;
        if (pos < 0) begin
            tag = "R6 negative position";
            return {1'b1, 1'b1, 1'b0, 3'd0, 4'd0, 8'd0};
        end
        set   = sym_now ? 0 : 1;
        where = 575 - pos;
        b     = m_dmap[set][where / 4];
        e     = (int'(b) >> ((3 - (where % 4)) * 2)) & 1;
        tag   = sym_now ? "R5 R6 R7 R8 R9 set0" : "R5 R6 R7 R8 R9 set1";
        return {1'b1, 1'b0, 1'b0, 3'((bank & 1) * 4 + e), 4'(1 << e), m_pmap[set][pos]};
    endfunction

    task automatic drive_req(input int code, input int qw, input int bank, input bit hit);
        req_valid    = 1'b1;
        req_syndrome = 9'(code);
        req_addr     = 16'(bank * 1024 + qw * 16 + (code & 15));
        req_bank     = 4'(bank);
        req_bank_hit = hit;
    endtask

    // One request: result read on the third falling edge, drop on the fourth.
    task automatic one_req(input int code, input int qw, input int bank, input bit hit,
                           input bit chk_drop);
        string tag;
        logic [17:0] exp;
        exp = model(code, qw, bank, hit, tag);
        drive_req(code, qw, bank, hit);
        @(negedge clk); req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(tag, outs(), exp);
        if (chk_drop) begin
            @(negedge clk);
            check("R2 single-cycle pulse", outs(), 18'd0);
        end
    endtask

    task automatic wr(input bit pin, input bit set, input int addr, input int data);
        wr_en = 1'b1; wr_pin_map = pin; wr_set = set;
        wr_addr = 10'(addr); wr_data = 8'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_sym(input bit v);
        sym_wr = 1'b1; sym_val = v;
        @(negedge clk);
        sym_wr = 1'b0; sym_now = v;
    endtask

    task automatic load_maps(input int pattern, input int set);
        for (int i = 0; i < 144; i++) begin
            m_dmap[set][i] = 8'(pattern == 0 ? i * 37 + set * 91 + 5 : i * 53 + 17);
            wr(1'b0, 1'(set), i, int'(m_dmap[set][i]));
        end
        for (int i = 0; i < 576; i++) begin
            m_pmap[set][i] = 8'(pattern == 0 ? i * 7 + set * 13 + 1 : i * 11 + 3);
            wr(1'b1, 1'(set), i, int'(m_pmap[set][i]));
        end
    endtask

    task automatic sweep(input int code_lo, input int code_hi, input int bank_hi);
        for (int bank = 0; bank <= bank_hi; bank++)
            for (int qw = 0; qw < 4; qw++)
                for (int code = code_lo; code <= code_hi; code++)
                    one_req(code, qw, bank, 1'b1, (code == 20 && qw == 1));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        string t0, t1, t2;
        logic [17:0] e0, e1, e2;
        // R1: reset holds outputs quiet even with a request applied.
        drive_req(-1, 0, 1, 1'b1);
        repeat (4) @(negedge clk);
        check("R1 during reset", outs(), 18'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 after reset", outs(), 18'd0);

        load_maps(0, 0);
        load_maps(0, 1);

        // R9: flag resets to 0, so set 1 is in use first.
        sym_now = 1'b0;
        sweep(-3, 150, 3);
        set_sym(1'b1);
        sweep(-3, 150, 3);

        // R3: no bank claims the address.
        one_req(5, 2, 0, 1'b0, 1'b1);
        one_req(-1, 0, 1, 1'b0, 1'b0);

        // R2: three requests on consecutive cycles.
        e0 = model(-1, 0, 1, 1'b1, t0);
        e1 = model(3, 2, 0, 1'b1, t1);
        e2 = model(144, 0, 1, 1'b1, t2);
        drive_req(-1, 0, 1, 1'b1); @(negedge clk);
        drive_req(3, 2, 0, 1'b1);  @(negedge clk);
        drive_req(144, 0, 1, 1'b1); @(negedge clk);
        req_valid = 1'b0;
        check({"R2 burst 1 ", t0}, outs(), e0);
        @(negedge clk); check({"R2 burst 2 ", t1}, outs(), e1);
        @(negedge clk); check({"R2 burst 3 ", t2}, outs(), e2);
        @(negedge clk); check("R2 burst end", outs(), 18'd0);

        // R10: out-of-range writes do nothing, in-range rewrites take effect.
        for (int i = 144; i < 150; i++) wr(1'b0, 1'b0, i, 8'hFF);
        for (int i = 576; i < 600; i++) wr(1'b1, 1'b0, i, 8'h00);
        wr(1'b0, 1'b0, 1000, 8'h55);
        sweep(-1, 144, 0);
        load_maps(1, 0);
        sweep(-1, 144, 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule